// File: doc/BRIEF.md
# Linked Command-List Register Sequencer

This block walks a chain of command lists held in memory and plays each one into its own register file. It fetches 32-bit words through a simple read port with one request in flight. Each list starts with a header word whose low 16 bits give the number of pairs. That many (register offset, value) pairs follow. The list ends with a link word that holds the byte address of the next list header. A link of zero ends the chain.

A host starts the engine through a small control port: it loads the list base register and writes the start bit of the command register. Pairs inside a list can program any writable register, including the interrupt enables, the hold bits and the blit launch register. A list can therefore ask for its own pause points and interrupts. The blit datapath itself is a stub that reports completion a fixed number of cycles after launch.

A soft-reset pair clears the configuration state. The engine then discards the pair that follows it, so list authors place a dummy pair right after it. The interrupt line is the OR of the pending bits masked by the enables.

Top module: `cmdlist_seq`

## Requirements
- R1: Writing 1 to bit 0 (start) of the command register (offset 0x10) while idle makes the first memory request go to the byte address held in the list base register (offset 0x0C).
- R2: A list is a header word (pair count in bits 15:0), then that many offset/value word pairs, then a link word; a nonzero link is fetched next as a list header, and a zero link ends the chain.
- R3: Each pair writes its value to the register whose offset is in bits 7:0 of the offset word; configuration register i sits at offset 0x40+4*i and reads back what was written.
- R4: A pair that writes bit 1 to the soft-reset register (offset 0x00) clears every configuration register, the interrupt enables and the hold bits, and the next pair of the list is discarded with no effect.
- R5: A pair writing bit 0 to the blit register (offset 0x1C) launches the blit stub; no memory request is issued until it completes, and each completion adds one to status bits 16:1 and sets pending bit 0.
- R6: Each list end adds one to status bits 24:17 and sets pending bit 1; with hold bit 1 (offset 0x18) set, the engine pauses after a nonzero link until bit 1 (continue) of the command register is written, and a continue written while not paused has no effect.
- R7: When the chain ends, status bit 0 (done) and pending bit 3 are set; a start clears done and both status counts.
- R8: Writing 1 to a bit of the pending register (offset 0x08) clears that bit only; the irq output is high exactly when a pending bit and the same bit of the enable register (offset 0x04) are both set.
- R9: Writing bit 2 (halt) of the command register while busy returns the engine to idle at the next pair boundary, before the next pair is fetched, and sets no pending bit or done bit; a later start runs normally.
- R10: A memory request keeps valid high and its address stable until accepted, and no new request is issued while a response is outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_we | input | 1 | Control write strobe |
| ctl_addr | input | 8 | Control register byte offset (read and write) |
| ctl_wdata | input | 32 | Control write data |
| ctl_rdata | output | 32 | Control read data for ctl_addr, combinational |
| mem_req_valid | output | 1 | Memory read request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | AW | Byte address of the requested word |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 32 | Read data word |
| irq | output | 1 | Masked OR of pending events |

## Verification
Programming is tried with a single short list, a two-list chain whose first list enables the interrupt, a list that opens with a soft reset followed by a payload, and a list with blit launches interleaved with plain writes. Together these separate a correct pair decoder from one that misplaces the offset or value word, mishandles the link word, or fails to skip the pair after a soft reset. A chain run with list hold set shows that the pause happens at the list boundary and that continue is honoured only while paused. A halt written right after start shows that the engine stops without applying later pairs or raising events. The memory model stalls its ready signal in a repeating pattern, so handshake holding and the single outstanding request are tested under back-pressure.

// File: rtl/cmdseq_pkg.sv
package cmdseq_pkg;
    localparam logic [7:0] OFS_SRST  = 8'h00;
    localparam logic [7:0] OFS_INTEN = 8'h04;
    localparam logic [7:0] OFS_PEND  = 8'h08;
    localparam logic [7:0] OFS_BASE  = 8'h0C;
    localparam logic [7:0] OFS_CMD   = 8'h10;
    localparam logic [7:0] OFS_STAT  = 8'h14;
    localparam logic [7:0] OFS_HOLD  = 8'h18;
    localparam logic [7:0] OFS_BLIT  = 8'h1C;
    localparam logic [7:0] OFS_CFG0  = 8'h40;

    localparam int EVT_W     = 4;
    localparam int HOLD_W    = 3;
    localparam int BLITCNT_W = 16;
    localparam int LISTCNT_W = 8;

    typedef enum logic [2:0] {ST_IDLE, ST_REQ, ST_WAIT, ST_DEC, ST_BLIT, ST_PAUSE} state_e;
    typedef enum logic [1:0] {PH_HDR, PH_OFS, PH_VAL, PH_LINK} phase_e;
endpackage

// File: rtl/cmdseq_blit_stub.sv
module cmdseq_blit_stub #(
    parameter int DELAY = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic go,
    output logic done
);
    localparam int CW = $clog2(DELAY + 1);
    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (go)
            cnt_d = CW'(DELAY);
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign done = (cnt_q == CW'(1));
endmodule

// File: rtl/cmdseq_regmux.sv
module cmdseq_regmux
    import cmdseq_pkg::*;
#(
    parameter int AW      = 32,
    parameter int CFG_NUM = 8
) (
    input  logic [7:0]                   addr,
    input  logic [EVT_W-1:0]             en,
    input  logic [EVT_W-1:0]             pend,
    input  logic [AW-1:0]                base,
    input  logic [HOLD_W-1:0]            hold,
    input  logic [BLITCNT_W-1:0]         nblit,
    input  logic [LISTCNT_W-1:0]         nlist,
    input  logic                         done,
    input  logic [CFG_NUM-1:0][31:0]     cfg,
    output logic [31:0]                  rdata
);
    always_comb begin
        rdata = '0;
        case (addr)
            OFS_INTEN: rdata = 32'(en);
            OFS_PEND:  rdata = 32'(pend);
            OFS_BASE:  rdata = 32'(base);
            OFS_HOLD:  rdata = 32'(hold);
            OFS_STAT:  rdata = {7'd0, nlist, nblit, done};
            default: begin
                for (int i = 0; i < CFG_NUM; i++)
                    if (addr == OFS_CFG0 + 8'(4 * i)) rdata = cfg[i];
            end
        endcase
    end
endmodule

// File: rtl/cmdlist_seq.sv
module cmdlist_seq
    import cmdseq_pkg::*;
#(
    parameter int AW         = 32,
    parameter int CFG_NUM    = 8,
    parameter int BLIT_DELAY = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ctl_we,
    input  logic [7:0]    ctl_addr,
    input  logic [31:0]   ctl_wdata,
    output logic [31:0]   ctl_rdata,
    output logic          mem_req_valid,
    input  logic          mem_req_ready,
    output logic [AW-1:0] mem_req_addr,
    input  logic          mem_rsp_valid,
    input  logic [31:0]   mem_rsp_data,
    output logic          irq
);
    typedef struct packed {
        state_e                    st;
        phase_e                    ph;
        logic [AW-1:0]             addr;
        logic [15:0]               left;
        logic [7:0]                ofs;
        logic                      skip;
        logic                      halt;
        logic [31:0]               word;
        logic [AW-1:0]             base;
        logic [EVT_W-1:0]          en;
        logic [EVT_W-1:0]          pend;
        logic [HOLD_W-1:0]         hold;
        logic [BLITCNT_W-1:0]      nblit;
        logic [LISTCNT_W-1:0]      nlist;
        logic                      done;
        logic                      go;
        logic [CFG_NUM-1:0][31:0]  cfg;
    } regs_t;

    regs_t d, q;
    logic  blit_go, blit_done;

    // Register write decode shared by host writes and list pairs.
    function automatic regs_t reg_wr(regs_t r, logic [7:0] a, logic [31:0] v);
        case (a)
            OFS_SRST: if (v[1]) begin
                r.cfg  = '0;
                r.en   = '0;
                r.hold = '0;
            end
            OFS_INTEN: r.en   = v[EVT_W-1:0];
            OFS_PEND:  r.pend = r.pend & ~v[EVT_W-1:0];
            OFS_BASE:  r.base = v[AW-1:0];
            OFS_HOLD:  r.hold = v[HOLD_W-1:0];
            default: begin
                for (int i = 0; i < CFG_NUM; i++)
                    if (a == OFS_CFG0 + 8'(4 * i)) r.cfg[i] = v;
            end
        endcase
        return r;
    endfunction

    // Move on to the next fetch, or stop here if a halt is waiting.
    function automatic regs_t fetch_next(regs_t r);
        if (r.halt) begin
            r.st   = ST_IDLE;
            r.halt = 1'b0;
        end else begin
            r.st = ST_REQ;
        end
        return r;
    endfunction

    always_comb begin
        d    = q;
        d.go = 1'b0;
        if (ctl_we) d = reg_wr(d, ctl_addr, ctl_wdata);

        case (q.st)
            ST_REQ:  if (mem_req_ready) d.st = ST_WAIT;
            ST_WAIT: if (mem_rsp_valid) begin
                d.word = mem_rsp_data;
                d.st   = ST_DEC;
            end
            ST_DEC: begin
                d.addr = q.addr + AW'(4);
                case (q.ph)
                    PH_HDR: begin
                        d.left = q.word[15:0];
                        d.ph   = (q.word[15:0] == 16'd0) ? PH_LINK : PH_OFS;
                        d      = fetch_next(d);
                    end
                    PH_OFS: begin
                        d.ofs = q.word[7:0];
                        d.ph  = PH_VAL;
                        d.st  = ST_REQ;
                    end
                    PH_VAL: begin
                        d.left = q.left - 16'd1;
                        d.ph   = (q.left == 16'd1) ? PH_LINK : PH_OFS;
                        if (q.skip) begin
                            d.skip = 1'b0;
                            d      = fetch_next(d);
                        end else begin
                            d = reg_wr(d, q.ofs, q.word);
                            if (q.ofs == OFS_SRST && q.word[1]) d.skip = 1'b1;
                            if (q.ofs == OFS_BLIT && q.word[0]) begin
                                d.st = ST_BLIT;
                                d.go = 1'b1;
                            end else begin
                                d = fetch_next(d);
                            end
                        end
                    end
                    default: begin
                        d.nlist   = q.nlist + 1'b1;
                        d.pend[1] = 1'b1;
                        if (q.word == 32'd0) begin
                            d.done    = 1'b1;
                            d.pend[3] = 1'b1;
                            d.st      = ST_IDLE;
                            d.halt    = 1'b0;
                        end else begin
                            d.addr = q.word[AW-1:0];
                            d.ph   = PH_HDR;
                            if (q.hold[1]) d.st = ST_PAUSE;
                            else           d = fetch_next(d);
                        end
                    end
                endcase
            end
            ST_BLIT: if (blit_done) begin
                d.nblit   = q.nblit + 1'b1;
                d.pend[0] = 1'b1;
                if (q.hold[0]) d.st = ST_PAUSE;
                else           d = fetch_next(d);
            end
            ST_PAUSE: if (q.halt) begin
                d.st   = ST_IDLE;
                d.halt = 1'b0;
            end
            default: ;
        endcase

        if (ctl_we && ctl_addr == OFS_CMD) begin
            if (ctl_wdata[0] && q.st == ST_IDLE) begin
                d.st    = ST_REQ;
                d.ph    = PH_HDR;
                d.addr  = q.base;
                d.nblit = '0;
                d.nlist = '0;
                d.done  = 1'b0;
                d.skip  = 1'b0;
                d.halt  = 1'b0;
            end
            if (ctl_wdata[1] && q.st == ST_PAUSE) d.st = ST_REQ;
            if (ctl_wdata[2] && q.st != ST_IDLE)  d.halt = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= ST_IDLE;
            q.ph <= PH_HDR;
        end else begin
            q <= d;
        end
    end

    assign blit_go       = q.go;
    assign mem_req_valid = (q.st == ST_REQ);
    assign mem_req_addr  = q.addr;
    assign irq           = |(q.pend & q.en);

    cmdseq_blit_stub #(.DELAY(BLIT_DELAY)) blit_i (
        .clk  (clk),
        .rst_n(rst_n),
        .go   (blit_go),
        .done (blit_done)
    );

    cmdseq_regmux #(.AW(AW), .CFG_NUM(CFG_NUM)) mux_i (
        .addr (ctl_addr),
        .en   (q.en),
        .pend (q.pend),
        .base (q.base),
        .hold (q.hold),
        .nblit(q.nblit),
        .nlist(q.nlist),
        .done (q.done),
        .cfg  (q.cfg),
        .rdata(ctl_rdata)
    );
endmodule

// File: rtl/cmdlist_seq_chk.sv
module cmdlist_seq_chk #(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          mem_req_valid,
    input logic          mem_req_ready,
    input logic [AW-1:0] mem_req_addr,
    input logic          mem_rsp_valid,
    input logic          blit_go,
    input logic          blit_done
);
    logic rsp_owed_q, blit_busy_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_owed_q  <= 1'b0;
            blit_busy_q <= 1'b0;
        end else begin
            if (mem_req_valid && mem_req_ready) rsp_owed_q <= 1'b1;
            else if (mem_rsp_valid)             rsp_owed_q <= 1'b0;
            if (blit_go)        blit_busy_q <= 1'b1;
            else if (blit_done) blit_busy_q <= 1'b0;
        end
    end

    assert_req_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

    assert_one_outstanding_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_owed_q |-> !mem_req_valid);

    assert_no_fetch_in_blit_R5: assert property (@(posedge clk) disable iff (!rst_n)
        blit_busy_q |-> !mem_req_valid);

    assert_blit_done_after_go_R5: assert property (@(posedge clk) disable iff (!rst_n)
        blit_done |-> blit_busy_q);
endmodule

bind cmdlist_seq cmdlist_seq_chk #(.AW(AW)) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .mem_req_valid(mem_req_valid),
    .mem_req_ready(mem_req_ready),
    .mem_req_addr (mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid),
    .blit_go      (blit_go),
    .blit_done    (blit_done)
);

// File: tb/cmdlist_seq_tb_top.sv
`timescale 1ns/1ps
module cmdlist_seq_tb_top;
    import cmdseq_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctl_we = 1'b0;
    logic [7:0]  ctl_addr = '0;
    logic [31:0] ctl_wdata = '0;
    logic [31:0] ctl_rdata;
    logic        mem_req_valid;
    logic        mem_req_ready = 1'b0;
    logic [31:0] mem_req_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_data = '0;
    logic        irq;

    int nchk = 0;
    int nfail = 0;
    int hs_viol = 0;
    logic [31:0] mem [0:255];
    logic [31:0] first_addr;
    logic        arm = 1'b0;

    always #10 clk = ~clk;

    cmdlist_seq #(.AW(32), .CFG_NUM(8), .BLIT_DELAY(4)) dut_i (
        .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_addr(ctl_addr),
        .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data(mem_rsp_data), .irq(irq)
    );

    // Memory model with a repeating stall pattern and a handshake monitor.
    logic [1:0]  stall_cnt = '0;
    logic        owed = 1'b0;
    logic        prev_stall = 1'b0;
    logic [31:0] prev_addr = '0;
    always @(posedge clk) begin
        stall_cnt     <= stall_cnt + 2'd1;
        mem_req_ready <= (stall_cnt != 2'd2);
        mem_rsp_valid <= 1'b0;
        if (mem_req_valid && owed) hs_viol <= hs_viol + 1;
        if (prev_stall && (!mem_req_valid || mem_req_addr != prev_addr)) hs_viol <= hs_viol + 1;
        prev_stall <= mem_req_valid && !mem_req_ready;
        prev_addr  <= mem_req_addr;
        if (mem_rsp_valid) owed <= 1'b0;
        if (mem_req_valid && mem_req_ready) begin
            owed          <= 1'b1;
            mem_rsp_valid <= 1'b1;
            mem_rsp_data  <= mem[mem_req_addr[9:2]];
            if (arm) begin
                first_addr <= mem_req_addr;
                arm        <= 1'b0;
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] v);
        @(negedge clk);
        ctl_we = 1'b1; ctl_addr = a; ctl_wdata = v;
        @(negedge clk);
        ctl_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] v);
        @(negedge clk);
        ctl_addr = a;
        #1 v = ctl_rdata;
    endtask

    function automatic logic [7:0] cfgo(input int i);
        return OFS_CFG0 + 8'(4 * i);
    endfunction

    task automatic wait_done();
        logic [31:0] s;
        for (int k = 0; k < 3000; k++) begin
            rd(OFS_STAT, s);
            if (s[0]) break;
        end
    endtask

    task automatic go(input logic [31:0] base);
        wr(OFS_BASE, base);
        arm = 1'b1;
        wr(OFS_CMD, 32'h1);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(OFS_STAT, v);  chk("reset status", v, 0);
        rd(OFS_PEND, v);  chk("reset pending", v, 0);
        chk("reset irq", 32'(irq), 0);
        chk("reset mem_req_valid", 32'(mem_req_valid), 0);
    endtask

    task automatic t_single();
        logic [31:0] v;
        mem[16] = 2;
        mem[17] = 32'(cfgo(0)); mem[18] = 32'hA5;
        mem[19] = 32'(cfgo(3)); mem[20] = 32'h1234;
        mem[21] = 0;
        go(32'h40);
        wait_done();
        chk("R1 first fetch address", first_addr, 32'h40);
        rd(cfgo(0), v); chk("R3 cfg0", v, 32'hA5);
        rd(cfgo(3), v); chk("R3 cfg3", v, 32'h1234);
        rd(OFS_STAT, v); chk("R7 status one list", v, (32'd1 << 17) | 32'd1);
        rd(OFS_PEND, v); chk("R7 pending list+chain", v, 32'hA);
        chk("R8 irq masked", 32'(irq), 0);
        wr(OFS_PEND, 32'hF);
        rd(OFS_PEND, v); chk("R8 pending cleared", v, 0);
        chk("R10 handshake violations", 32'(hs_viol), 0);
    endtask

    task automatic t_chain();
        logic [31:0] v;
        mem[32] = 1; mem[33] = 32'(OFS_INTEN); mem[34] = 32'h8; mem[35] = 32'h100;
        mem[64] = 1; mem[65] = 32'(cfgo(1)); mem[66] = 32'hBEEF; mem[67] = 0;
        go(32'h80);
        wait_done();
        rd(cfgo(1), v); chk("R2 second list applied", v, 32'hBEEF);
        rd(OFS_STAT, v); chk("R2 two lists counted", v, (32'd2 << 17) | 32'd1);
        chk("R8 irq from enabled chain end", 32'(irq), 1);
        wr(OFS_PEND, 32'h2);
        rd(OFS_PEND, v); chk("R8 clear only bit1", v, 32'h8);
        chk("R8 irq still high", 32'(irq), 1);
        wr(OFS_PEND, 32'h8);
        chk("R8 irq low after clear", 32'(irq), 0);
        wr(OFS_INTEN, 0);
    endtask

    task automatic t_softreset();
        logic [31:0] v;
        wr(cfgo(1), 32'h11);
        wr(OFS_INTEN, 32'h1);
        wr(OFS_HOLD, 32'h4);
        mem[96] = 3;
        mem[97]  = 32'(OFS_SRST); mem[98]  = 32'h2;
        mem[99]  = 32'(cfgo(2));  mem[100] = 32'h77;
        mem[101] = 32'(cfgo(5));  mem[102] = 32'h55;
        mem[103] = 0;
        go(32'h180);
        wait_done();
        rd(cfgo(1), v);  chk("R4 cfg cleared", v, 0);
        rd(cfgo(2), v);  chk("R4 pair after reset discarded", v, 0);
        rd(cfgo(5), v);  chk("R4 later pair applied", v, 32'h55);
        rd(OFS_INTEN, v); chk("R4 enables cleared", v, 0);
        rd(OFS_HOLD, v); chk("R4 hold cleared", v, 0);
        wr(OFS_PEND, 32'hF);
    endtask

    task automatic t_blit();
        logic [31:0] v;
        mem[112] = 3;
        mem[113] = 32'(OFS_BLIT); mem[114] = 32'h1;
        mem[115] = 32'(cfgo(0));  mem[116] = 32'h9;
        mem[117] = 32'(OFS_BLIT); mem[118] = 32'h1;
        mem[119] = 0;
        go(32'h1C0);
        wait_done();
        rd(OFS_STAT, v); chk("R5 two blits counted", v, (32'd1 << 17) | (32'd2 << 1) | 32'd1);
        rd(OFS_PEND, v); chk("R5 blit pending bit", v, 32'hB);
        rd(cfgo(0), v);  chk("R5 write between blits", v, 32'h9);
        wr(OFS_PEND, 32'hF);
    endtask

    task automatic t_listhold();
        logic [31:0] v;
        int seen = 0;
        wr(OFS_HOLD, 32'h2);
        mem[128] = 1; mem[129] = 32'(cfgo(4)); mem[130] = 32'h44; mem[131] = 32'h240;
        mem[144] = 1; mem[145] = 32'(cfgo(4)); mem[146] = 32'h45; mem[147] = 0;
        go(32'h200);
        for (int k = 0; k < 500; k++) begin
            rd(OFS_PEND, v);
            if (v[1]) break;
        end
        repeat (20) begin
            @(negedge clk);
            if (mem_req_valid) seen++;
        end
        chk("R6 no fetch while paused", 32'(seen), 0);
        rd(OFS_STAT, v); chk("R6 paused after first list", v, 32'd1 << 17);
        rd(cfgo(4), v);  chk("R6 first list applied", v, 32'h44);
        wr(OFS_CMD, 32'h2);
        wait_done();
        rd(OFS_STAT, v); chk("R6 resumed to chain end", v, (32'd2 << 17) | 32'd1);
        rd(cfgo(4), v);  chk("R6 second list applied", v, 32'h45);
        wr(OFS_CMD, 32'h2);
        seen = 0;
        repeat (10) begin
            @(negedge clk);
            if (mem_req_valid) seen++;
        end
        chk("R6 continue while idle ignored", 32'(seen), 0);
        rd(OFS_STAT, v); chk("R6 status unchanged after stray continue", v, (32'd2 << 17) | 32'd1);
        wr(OFS_HOLD, 0);
        wr(OFS_PEND, 32'hF);
    endtask

    task automatic t_halt();
        logic [31:0] v;
        wr(OFS_SRST, 32'h2);
        mem[160] = 4;
        mem[161] = 32'(cfgo(0)); mem[162] = 32'h1;
        mem[163] = 32'(cfgo(1)); mem[164] = 32'h2;
        mem[165] = 32'(cfgo(6)); mem[166] = 32'h3;
        mem[167] = 32'(cfgo(7)); mem[168] = 32'h4;
        mem[169] = 0;
        go(32'h280);
        wr(OFS_CMD, 32'h4);
        repeat (30) @(negedge clk);
        chk("R9 idle after halt", 32'(mem_req_valid), 0);
        rd(cfgo(6), v); chk("R9 later pair not applied", v, 0);
        rd(cfgo(7), v); chk("R9 last pair not applied", v, 0);
        rd(OFS_PEND, v); chk("R9 no pending on halt", v, 0);
        rd(OFS_STAT, v); chk("R9 done not set", 32'(v[0]), 0);
        go(32'h280);
        wait_done();
        rd(cfgo(7), v); chk("R9 restart runs full list", v, 32'h4);
        wr(OFS_PEND, 32'hF);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = '0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        t_single();
        t_chain();
        t_softreset();
        t_blit();
        t_listhold();
        t_halt();
        chk("R10 handshake violations total", 32'(hs_viol), 0);
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        nchk++;
        nfail++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end
endmodule